// File: doc/BRIEF.md
# Program Memory Table Read Unit

This block carries out the table-read operation of a small microcontroller core. Software loads an 8-bit low pointer and an 8-bit high pointer through a register write port. A start strobe then fetches one 16-bit word from a 4096-word program memory. The low byte of that word is returned on a destination write port, tagged with the destination index given at start. The high byte is loaded into a separate high-byte holding register. Software can also read and write that register directly.

There are two addressing modes. The normal mode joins the lower four bits of the high pointer with the full low pointer. The last-page mode ignores the high pointer and uses the top page of memory, 0xF00, plus the low pointer. A decrement strobe steps the low pointer down, so that software can walk backwards through a table.

Program memory sits outside the block. It is reached through a synchronous read port with a one-cycle latency. A read is issued in the cycle a start strobe is accepted.

The destination write port carries no ready signal, because every operation takes a fixed two cycles and the core cannot stall it. The start strobes likewise have no back-pressure: a strobe that arrives while the unit is busy is dropped.

An interlock input can hold the interrupt enable low for the whole operation. This stops an interrupt routine from overwriting the high-byte register in the middle of a main-routine read.

Top module: `tblrd_unit`

## Requirements
- R1: After reset, `ptr_lo`, `ptr_hi` and `tblh` are 0x00, and `busy` and `dst_we` are low.
- R2: When `start_norm` is accepted, `rom_en` is high in that same cycle and `rom_addr` = {`ptr_hi`[3:0], `ptr_lo`}.
- R3: When `start_last` is accepted, `rom_addr` = {4'hF, `ptr_lo`}, whatever the value of `ptr_hi`.
- R4: Let the accepting edge be E0. `dst_we` stays low in the cycle after E0. It is high for exactly one cycle after edge E1. In that cycle `dst_data` is the low byte of the fetched word, and `tblh` holds the high byte.
- R5: `busy` is high for exactly the two cycles after the accepting edge. A start strobe seen while `busy` is high gives no `rom_en` and no extra `dst_we`.
- R6: A register write with `reg_sel`=2'b10 loads `tblh`, which can then be read back. A table read overwrites it. If a software write lands on the same edge as the table-read load, the table-read value wins.
- R7: `ptr_dec` lowers `ptr_lo` by one and wraps from 0x00 to 0xFF, with `ptr_hi` unchanged. A read after a decrement fetches the preceding word.
- R8: Bits [7:4] of `ptr_hi` do not affect `rom_addr`.
- R9: With `int_lock` high, `int_en_out` is low from the accepting cycle until `busy` falls. Otherwise `int_en_out` follows `int_en_in`.
- R10: A register write to the low pointer (`reg_sel`=2'b00) on the same edge as `ptr_dec` takes priority over the decrement. `reg_sel`=2'b01 selects the high pointer.
- R11: If `start_norm` and `start_last` are both high, the last-page mode is used.
- R12: `dst_idx` during the `dst_we` cycle equals the `dst_idx_in` value seen on the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | 00 low pointer, 01 high pointer, 10 high-byte register, 11 none |
| reg_wdata | input | 8 | Register write data |
| ptr_dec | input | 1 | Decrement the low pointer |
| start_norm | input | 1 | Start a read in normal mode |
| start_last | input | 1 | Start a read in last-page mode |
| dst_idx_in | input | 5 | Destination register index for the read |
| int_en_in | input | 1 | Interrupt enable from the core |
| int_lock | input | 1 | Hold interrupts off during reads |
| rom_en | output | 1 | Program memory read enable |
| rom_addr | output | 12 | Program memory word address |
| rom_data | input | 16 | Program memory data, one cycle after rom_en |
| dst_we | output | 1 | Destination write enable |
| dst_idx | output | 5 | Destination register index |
| dst_data | output | 8 | Low byte of the fetched word |
| tblh | output | 8 | High-byte register value |
| ptr_lo | output | 8 | Low pointer value |
| ptr_hi | output | 8 | High pointer value |
| busy | output | 1 | Operation in progress |
| int_en_out | output | 1 | Gated interrupt enable |

## Verification
Each internal fault in this unit shows up at the ports within two cycles of a read being accepted.

- A corrupted pointer register shows on `rom_addr` in the start cycle itself, and again in the returned data pair one edge later.
- A sequencer stuck in or skipping a state shows up as a `busy` pulse that is not two cycles long, or as a missing or doubled `dst_we`.
- A wrong priority on the high-byte register shows in `tblh` in the same cycle as `dst_we`.

The bench therefore samples every read at its start cycle, at both busy cycles and at the first idle cycle after it.

// File: rtl/tblrd_pkg.sv
package tblrd_pkg;
  localparam int PTR_W  = 8;
  localparam int ADDR_W = 12;
  localparam int WORD_W = 16;
  localparam int IDX_W  = 5;

  typedef enum logic [1:0] {
    SEL_LO   = 2'b00,
    SEL_HI   = 2'b01,
    SEL_TBLH = 2'b10,
    SEL_NONE = 2'b11
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_FETCH = 2'b01,
    ST_WRITE = 2'b10
  } tr_state_e;
endpackage

// File: rtl/tblrd_ptr.sv
module tblrd_ptr #(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [PTR_W-1:0] wdata,
  input  logic             dec,
  output logic [PTR_W-1:0] lo_q,
  output logic [PTR_W-1:0] hi_q
);
  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  // Low pointer: a software write wins over a decrement on the same edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lo_q <= '0;
    else if (wr_lo) lo_q <= wdata;
    else if (dec)   lo_q <= lo_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_q <= '0;
    else if (wr_hi) hi_q <= wdata;
  end

  p_dec_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !wr_lo && lo_q == '0) |=> (lo_q == '1));
  p_dec_keeps_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !wr_hi) |=> $stable(hi_q));
  p_write_beats_dec_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && dec) |=> (lo_q == $past(wdata)));
endmodule

// File: rtl/tblrd_addr.sv
module tblrd_addr #(
  parameter int PTR_W  = 8,
  parameter int ADDR_W = 12
) (
  input  logic                    use_last,
  input  logic [ADDR_W-PTR_W-1:0] page,
  input  logic [PTR_W-1:0]        offset,
  output logic [ADDR_W-1:0]       addr
);
  localparam int PAGE_W = ADDR_W - PTR_W;
  localparam logic [PAGE_W-1:0] LAST_PAGE = '1;

  generate
    if (PAGE_W > 0) begin : g_paged
      always_comb addr = {(use_last ? LAST_PAGE : page), offset};
    end else begin : g_flat
      always_comb addr = offset[ADDR_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/tblrd_ctrl.sv
module tblrd_ctrl
  import tblrd_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int IDX_W  = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_any,
  input  logic [IDX_W-1:0]    idx_in,
  input  logic [WORD_W-1:0]   word,
  input  logic                sw_tblh_we,
  input  logic [WORD_W/2-1:0] sw_tblh_data,
  output logic                accept,
  output logic                busy,
  output logic                dst_we,
  output logic [IDX_W-1:0]    dst_idx,
  output logic [WORD_W/2-1:0] dst_data,
  output logic [WORD_W/2-1:0] tblh
);
  localparam int HALF = WORD_W / 2;

  tr_state_e state_q, state_d;

  always_comb begin
    accept  = start_any && (state_q == ST_IDLE);
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = ST_FETCH;
      ST_FETCH: state_d = ST_WRITE;
      ST_WRITE: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy   = (state_q != ST_IDLE);
  assign dst_we = (state_q == ST_WRITE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dst_idx <= '0;
    else if (accept) dst_idx <= idx_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    dst_data <= '0;
    else if (state_q == ST_FETCH)  dst_data <= word[HALF-1:0];
  end

  // Holding register: the table-read load wins over a software write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    tblh <= '0;
    else if (state_q == ST_FETCH)  tblh <= word[WORD_W-1:HALF];
    else if (sw_tblh_we)           tblh <= sw_tblh_data;
  end

  p_busy_two_cycles_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy ##1 busy ##1 !busy);
  p_we_second_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !dst_we ##1 dst_we ##1 !dst_we);
  p_result_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dst_we |-> (dst_data == $past(word[HALF-1:0]) && tblh == $past(word[WORD_W-1:HALF])));
  p_idx_kept_r12: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ##1 (dst_idx == $past(idx_in, 2)));
endmodule

// File: rtl/tblrd_unit.sv
module tblrd_unit
  import tblrd_pkg::*;
#(
  parameter int P_PTR_W  = PTR_W,
  parameter int P_ADDR_W = ADDR_W,
  parameter int P_WORD_W = WORD_W,
  parameter int P_IDX_W  = IDX_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [1:0]            reg_sel,
  input  logic [P_PTR_W-1:0]    reg_wdata,
  input  logic                  ptr_dec,
  input  logic                  start_norm,
  input  logic                  start_last,
  input  logic [P_IDX_W-1:0]    dst_idx_in,
  input  logic                  int_en_in,
  input  logic                  int_lock,
  output logic                  rom_en,
  output logic [P_ADDR_W-1:0]   rom_addr,
  input  logic [P_WORD_W-1:0]   rom_data,
  output logic                  dst_we,
  output logic [P_IDX_W-1:0]    dst_idx,
  output logic [P_WORD_W/2-1:0] dst_data,
  output logic [P_WORD_W/2-1:0] tblh,
  output logic [P_PTR_W-1:0]    ptr_lo,
  output logic [P_PTR_W-1:0]    ptr_hi,
  output logic                  busy,
  output logic                  int_en_out
);
  localparam int PAGE_W = P_ADDR_W - P_PTR_W;

  logic wr_lo, wr_hi, wr_tblh, accept;

  assign wr_lo   = reg_we && (reg_sel == SEL_LO);
  assign wr_hi   = reg_we && (reg_sel == SEL_HI);
  assign wr_tblh = reg_we && (reg_sel == SEL_TBLH);

  tblrd_ptr #(.PTR_W(P_PTR_W)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_lo (wr_lo),
    .wr_hi (wr_hi),
    .wdata (reg_wdata),
    .dec   (ptr_dec),
    .lo_q  (ptr_lo),
    .hi_q  (ptr_hi)
  );

  tblrd_addr #(.PTR_W(P_PTR_W), .ADDR_W(P_ADDR_W)) u_addr (
    .use_last (start_last),
    .page     (ptr_hi[PAGE_W-1:0]),
    .offset   (ptr_lo),
    .addr     (rom_addr)
  );

  tblrd_ctrl #(.WORD_W(P_WORD_W), .IDX_W(P_IDX_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_any    (start_norm || start_last),
    .idx_in       (dst_idx_in),
    .word         (rom_data),
    .sw_tblh_we   (wr_tblh),
    .sw_tblh_data (reg_wdata),
    .accept       (accept),
    .busy         (busy),
    .dst_we       (dst_we),
    .dst_idx      (dst_idx),
    .dst_data     (dst_data),
    .tblh         (tblh)
  );

  assign rom_en     = accept;
  assign int_en_out = int_en_in && !(int_lock && (busy || accept));

  p_no_start_when_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rom_en);
  p_last_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_last && !busy) |-> (rom_en && rom_addr[P_ADDR_W-1:P_PTR_W] == '1));
  p_lock_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (int_lock && busy) |-> !int_en_out);
  p_norm_offset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rom_en |-> (rom_addr[P_PTR_W-1:0] == ptr_lo));
endmodule

// File: tb/test_tblrd_unit.sv
module test_tblrd_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we = 0;
  logic [1:0]  reg_sel = 2'b11;
  logic [7:0]  reg_wdata = 0;
  logic        ptr_dec = 0, start_norm = 0, start_last = 0;
  logic [4:0]  dst_idx_in = 0;
  logic        int_en_in = 1, int_lock = 0;
  logic        rom_en;
  logic [11:0] rom_addr;
  logic [15:0] rom_data = 0;
  logic        dst_we;
  logic [4:0]  dst_idx;
  logic [7:0]  dst_data, tblh, ptr_lo, ptr_hi;
  logic        busy, int_en_out;
  int n_cmp = 0, n_bad = 0;

  always #5 clk = ~clk;

  tblrd_unit i_tblrd_unit (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .ptr_dec(ptr_dec), .start_norm(start_norm), .start_last(start_last),
    .dst_idx_in(dst_idx_in), .int_en_in(int_en_in), .int_lock(int_lock),
    .rom_en(rom_en), .rom_addr(rom_addr), .rom_data(rom_data), .dst_we(dst_we),
    .dst_idx(dst_idx), .dst_data(dst_data), .tblh(tblh), .ptr_lo(ptr_lo),
    .ptr_hi(ptr_hi), .busy(busy), .int_en_out(int_en_out)
  );

  function automatic logic [15:0] romf(logic [11:0] a);
    return {a[3:0], a[11:8], a[7:0]} ^ 16'hA5C3;
  endfunction

  always_ff @(posedge clk) if (rom_en) rom_data <= romf(rom_addr);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [1:0] sel, logic [7:0] val);
    @(negedge clk); reg_we = 1; reg_sel = sel; reg_wdata = val;
    @(negedge clk); reg_we = 0; reg_sel = 2'b11;
  endtask

  task automatic dec_lo();
    @(negedge clk); ptr_dec = 1;
    @(negedge clk); ptr_dec = 0;
  endtask

  // Full read: start cycle, two busy cycles, first idle cycle.
  task automatic do_read(bit nrm, bit lst, logic [4:0] idx, logic [11:0] exp_a,
                         string areq, bit exp_ie);
    logic [15:0] w;
    w = romf(exp_a);
    @(negedge clk); start_norm = nrm; start_last = lst; dst_idx_in = idx; #1;
    chk({areq, " rom_en"}, rom_en, 1);
    chk({areq, " rom_addr"}, rom_addr, exp_a);
    chk("R9 int_en start", int_en_out, exp_ie);
    @(negedge clk); start_norm = 0; start_last = 0; dst_idx_in = ~idx;
    chk("R5 busy c1", busy, 1);
    chk("R4 dst_we low c1", dst_we, 0);
    chk("R9 int_en c1", int_en_out, exp_ie);
    @(negedge clk);
    chk("R5 busy c2", busy, 1);
    chk("R4 dst_we c2", dst_we, 1);
    chk("R4 dst_data", dst_data, w[7:0]);
    chk("R4 tblh", tblh, w[15:8]);
    chk("R12 dst_idx", dst_idx, idx);
    chk("R9 int_en c2", int_en_out, exp_ie);
    @(negedge clk);
    chk("R5 busy done", busy, 0);
    chk("R4 dst_we done", dst_we, 0);
    chk("R9 int_en done", int_en_out, int_en_in);
  endtask

  task automatic t_reset();
    chk("R1 ptr_lo", ptr_lo, 0);
    chk("R1 ptr_hi", ptr_hi, 0);
    chk("R1 tblh", tblh, 0);
    chk("R1 busy", busy, 0);
    chk("R1 dst_we", dst_we, 0);
  endtask

  task automatic t_normal();
    wr_reg(2'b01, 8'h3A);
    wr_reg(2'b00, 8'h47);
    chk("R10 hi write", ptr_hi, 8'h3A);
    do_read(1, 0, 5'd9, 12'hA47, "R2 R8", 1);
    wr_reg(2'b01, 8'hC2);
    wr_reg(2'b00, 8'hF0);
    do_read(1, 0, 5'd30, 12'h2F0, "R2 R8", 1);
  endtask

  task automatic t_last();
    wr_reg(2'b01, 8'h3A);
    wr_reg(2'b00, 8'h06);
    do_read(0, 1, 5'd3, 12'hF06, "R3", 1);
    dec_lo();
    chk("R7 lo after dec", ptr_lo, 8'h05);
    do_read(0, 1, 5'd4, 12'hF05, "R7 R3", 1);
    do_read(1, 1, 5'd5, 12'hF05, "R11", 1);
  endtask

  task automatic t_wrap();
    wr_reg(2'b01, 8'h5B);
    wr_reg(2'b00, 8'h00);
    dec_lo();
    chk("R7 wrap lo", ptr_lo, 8'hFF);
    chk("R7 wrap hi", ptr_hi, 8'h5B);
    @(negedge clk); reg_we = 1; reg_sel = 2'b00; reg_wdata = 8'h20; ptr_dec = 1;
    @(negedge clk); reg_we = 0; reg_sel = 2'b11; ptr_dec = 0;
    chk("R10 write over dec", ptr_lo, 8'h20);
  endtask

  task automatic t_busy_start();
    int pulses = 0;
    @(negedge clk); start_norm = 1;
    @(negedge clk); #1;
    chk("R5 no rom_en busy", rom_en, 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (i == 0) start_norm = 0;
      if (dst_we) pulses++;
    end
    chk("R5 one dst_we", pulses, 1);
  endtask

  task automatic t_tblh();
    logic [15:0] w;
    wr_reg(2'b10, 8'h5E);
    chk("R6 tblh sw", tblh, 8'h5E);
    wr_reg(2'b01, 8'h07);
    wr_reg(2'b00, 8'h81);
    w = romf(12'h781);
    @(negedge clk); start_norm = 1;
    @(negedge clk); start_norm = 0; reg_we = 1; reg_sel = 2'b10; reg_wdata = 8'hEE;
    @(negedge clk); reg_we = 0; reg_sel = 2'b11;
    chk("R6 read wins", tblh, w[15:8]);
    @(negedge clk);
    wr_reg(2'b10, 8'h11);
    chk("R6 sw after", tblh, 8'h11);
    do_read(1, 0, 5'd1, 12'h781, "R6 overwrite", 1);
  endtask

  task automatic t_lock();
    int_lock = 1;
    do_read(1, 0, 5'd7, 12'h781, "R9 locked", 0);
    int_lock = 0;
    do_read(1, 0, 5'd8, 12'h781, "R9 open", 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_last();
    t_wrap();
    t_busy_start();
    t_tblh();
    t_lock();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule